// File: doc/BRIEF.md
# Floating-point exception and trap controller

This block keeps the floating-point control and status state of a processor core whose floating-point arithmetic runs in software. A control word holds the rounding mode and one trap-enable bit per exception type. A separate exception word holds two copies of the five exception flags:
- the "actual" flags, which describe the most recent operation only;
- the "accrued" flags, which are sticky and collect every exception seen since software last cleared them.

When the software arithmetic finishes an operation, it pulses an operation-complete strobe. With the strobe it presents three things: the exception vector it computed and the high words of both operands. The block then does the following:
- it classifies each operand word as an ordinary number, a quiet NaN or a signaling NaN;
- it forces the invalid-operation flag when either operand is a signaling NaN;
- it updates both flag sets;
- it raises a one-cycle trap request when any newly reported exception has its trap enabled.

It also gives a one-cycle write enable for the integer condition flags, but only when the completed operation was a floating-point compare.

Both words are read and written through plain register ports. All state changes on the rising clock edge and is visible on the read ports the cycle after. Reset is synchronous and active high.

Top module: `fp_exc_ctrl`

## Requirements
- R1: The rounding mode is control-word bits 14..13, with the encoding 00 = to nearest, 01 = toward zero, 10 = toward minus infinity, 11 = toward plus infinity. A control write loads it, and both `ctl_rdata` and `rnd_mode` show it from the next cycle.
- R2: The trap enables are control-word bits 12..8, in the order bit 12 invalid operation, bit 11 division by zero, bit 10 overflow, bit 9 underflow, bit 8 inexact. Every other control-word bit reads as zero.
- R3: The exception word holds the actual flags at bits 12..8 and the accrued flags at bits 4..0. Both use the trap-enable type order, and the exception vector `op_exc` uses the same order at bits 4..0.
- R4: On a cycle with `op_done` high, the actual flags are replaced by that operation's effective vector, and the accrued flags become their old value ORed with it. The result reads back on the next cycle.
- R5: Exception-word bits 31..13 and 7..5 always read as zero, and writes to them are discarded.
- R6: An operand word is a NaN exactly when its bits 30..19 are all ones. On `op_done` each operand's class is registered: 00 = not a NaN, 01 = quiet NaN, 10 = signaling NaN.
- R7: For a NaN word, bit 0 = 0 means quiet and bit 0 = 1 means signaling. Bit 31 and bits 18..1 do not affect the class.
- R8: If either operand is a signaling NaN, the effective vector has its invalid-operation bit (bit 4) set, even when `op_exc` bit 4 is zero.
- R9: `trap_req` is high for exactly the cycle after an `op_done` whose effective vector ANDed with the trap enables held before that edge is nonzero. It is low in every other cycle.
- R10: `flag_we` is high for exactly the cycle after an `op_done` with `op_cmp` high, and low in every other cycle.
- R11: A software write to the exception word loads both fields from the next cycle. When `exc_we` and `op_done` fall in the same cycle, the strobe update wins and the written data is dropped.
- R12: A synchronous reset clears the rounding mode, the trap enables, both flag sets, the operand classes, `trap_req` and `flag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-word write enable |
| ctl_wdata | input | 32 | Control-word write data |
| ctl_rdata | output | 32 | Control-word read data |
| rnd_mode | output | 2 | Current rounding mode |
| exc_we | input | 1 | Exception-word write enable |
| exc_wdata | input | 32 | Exception-word write data |
| exc_rdata | output | 32 | Exception-word read data |
| op_done | input | 1 | Operation-complete strobe |
| op_exc | input | 5 | Exceptions reported by the arithmetic |
| op_a_hi | input | 32 | High word of operand A |
| op_b_hi | input | 32 | High word of operand B |
| op_cmp | input | 1 | Completed operation is a compare |
| a_class | output | 2 | Registered class of operand A |
| b_class | output | 2 | Registered class of operand B |
| trap_req | output | 1 | One-cycle trap request |
| flag_we | output | 1 | One-cycle condition-flag write enable |

## Verification
The bench builds the block with its default parameters:
- a 32-bit word;
- five exception types;
- the NaN field at bits 30..19;
- fields at the bit positions listed above.

Because the bit positions are the defaults, the bench can write the exact literal words a software handler would use. This lets it check that reserved bits are discarded. It also lets it probe NaN near-misses one bit below the field and payload-only words.

Directed operations cover quiet and signaling NaNs, enabled and masked traps, compare and non-compare completions, and a software write colliding with a strobe. A long run of random operations, control writes and NaN-biased operand words is then compared with the behavioural model on every clock.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;

  typedef enum logic [1:0] {
    NC_NUMBER = 2'b00,
    NC_QUIET  = 2'b01,
    NC_SIGNAL = 2'b10
  } nan_class_e;

  localparam int N_OPS = 2;

endpackage

// File: rtl/fp_nan_classify.sv
module fp_nan_classify
  import fp_exc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NAN_LO = 19,
  parameter int NAN_HI = 30
) (
  input  logic [WORD_W-1:0] word_i,
  output nan_class_e        class_o
);

  localparam int FIELD_W = NAN_HI - NAN_LO + 1;

  logic [FIELD_W-1:0] exp_field;
  logic               is_nan;
  logic               unused_word;

  assign exp_field   = word_i[NAN_HI:NAN_LO];
  assign is_nan      = &exp_field;
  assign unused_word = ^word_i;

  always_comb begin
    if (!is_nan)        class_o = NC_NUMBER;
    else if (word_i[0]) class_o = NC_SIGNAL;
    else                class_o = NC_QUIET;
  end

endmodule

// File: rtl/fp_ctl_reg.sv
module fp_ctl_reg #(
  parameter int WORD_W = 32,
  parameter int RM_W   = 2,
  parameter int RM_LSB = 13,
  parameter int EXC_W  = 5,
  parameter int TE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [RM_W-1:0]   rm_o,
  output logic [EXC_W-1:0]  te_o,
  output logic [WORD_W-1:0] rdata_o
);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rm_o <= '0;
      te_o <= '0;
    end else if (we_i) begin
      rm_o <= wdata_i[RM_LSB +: RM_W];
      te_o <= wdata_i[TE_LSB +: EXC_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[RM_LSB +: RM_W]  = rm_o;
    rdata_o[TE_LSB +: EXC_W] = te_o;
  end

endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status #(
  parameter int WORD_W  = 32,
  parameter int EXC_W   = 5,
  parameter int ACT_LSB = 8,
  parameter int ACC_LSB = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  input  logic              upd_i,
  input  logic [EXC_W-1:0]  upd_vec_i,
  output logic [EXC_W-1:0]  act_o,
  output logic [EXC_W-1:0]  acc_o,
  output logic [WORD_W-1:0] rdata_o
);

  logic unused_wdata;
  assign unused_wdata = ^sw_wdata_i;

  // Strobe update has priority over a software write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_o <= '0;
      acc_o <= '0;
    end else if (upd_i) begin
      act_o <= upd_vec_i;
      acc_o <= acc_o | upd_vec_i;
    end else if (sw_we_i) begin
      act_o <= sw_wdata_i[ACT_LSB +: EXC_W];
      acc_o <= sw_wdata_i[ACC_LSB +: EXC_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[ACT_LSB +: EXC_W] = act_o;
    rdata_o[ACC_LSB +: EXC_W] = acc_o;
  end

endmodule

// File: rtl/fp_trap_gen.sv
module fp_trap_gen #(
  parameter int EXC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic             is_cmp_i,
  input  logic [EXC_W-1:0] vec_i,
  input  logic [EXC_W-1:0] te_i,
  output logic             trap_o,
  output logic             flag_we_o
);

  logic [EXC_W-1:0] hit;
  assign hit = vec_i & te_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o    <= 1'b0;
      flag_we_o <= 1'b0;
    end else begin
      trap_o    <= upd_i && (|hit);
      flag_we_o <= upd_i && is_cmp_i;
    end
  end

endmodule

// File: rtl/fp_exc_ctrl.sv
module fp_exc_ctrl
  import fp_exc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int EXC_W   = 5,
  parameter int RM_W    = 2,
  parameter int RM_LSB  = 13,
  parameter int TE_LSB  = 8,
  parameter int ACT_LSB = 8,
  parameter int ACC_LSB = 0,
  parameter int NAN_LO  = 19,
  parameter int NAN_HI  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  output logic [WORD_W-1:0] ctl_rdata,
  output logic [RM_W-1:0]   rnd_mode,
  input  logic              exc_we,
  input  logic [WORD_W-1:0] exc_wdata,
  output logic [WORD_W-1:0] exc_rdata,
  input  logic              op_done,
  input  logic [EXC_W-1:0]  op_exc,
  input  logic [WORD_W-1:0] op_a_hi,
  input  logic [WORD_W-1:0] op_b_hi,
  input  logic              op_cmp,
  output logic [1:0]        a_class,
  output logic [1:0]        b_class,
  output logic              trap_req,
  output logic              flag_we
);

  localparam int INV_BIT = EXC_W - 1;

  logic [EXC_W-1:0]  trap_en;
  logic [EXC_W-1:0]  act_flags;
  logic [EXC_W-1:0]  acc_flags;
  logic [EXC_W-1:0]  eff_vec;
  logic [WORD_W-1:0] opw      [N_OPS];
  nan_class_e        op_cls   [N_OPS];
  logic [N_OPS-1:0]  op_snan;
  logic [1:0]        cls_q    [N_OPS];
  logic              unused_flags;

  assign opw[0] = op_a_hi;
  assign opw[1] = op_b_hi;

  fp_ctl_reg #(
    .WORD_W(WORD_W), .RM_W(RM_W), .RM_LSB(RM_LSB),
    .EXC_W(EXC_W), .TE_LSB(TE_LSB)
  ) u_ctl (
    .clk(clk), .rst(rst), .we_i(ctl_we), .wdata_i(ctl_wdata),
    .rm_o(rnd_mode), .te_o(trap_en), .rdata_o(ctl_rdata)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fp_nan_classify #(
      .WORD_W(WORD_W), .NAN_LO(NAN_LO), .NAN_HI(NAN_HI)
    ) u_cls (
      .word_i(opw[g]), .class_o(op_cls[g])
    );

    assign op_snan[g] = (op_cls[g] == NC_SIGNAL);

    always_ff @(posedge clk) begin
      if (rst)          cls_q[g] <= NC_NUMBER;
      else if (op_done) cls_q[g] <= op_cls[g];
    end
  end

  assign a_class = cls_q[0];
  assign b_class = cls_q[1];

  always_comb begin
    eff_vec = op_exc;
    if (|op_snan) eff_vec[INV_BIT] = 1'b1;
  end

  fp_exc_status #(
    .WORD_W(WORD_W), .EXC_W(EXC_W), .ACT_LSB(ACT_LSB), .ACC_LSB(ACC_LSB)
  ) u_status (
    .clk(clk), .rst(rst), .sw_we_i(exc_we), .sw_wdata_i(exc_wdata),
    .upd_i(op_done), .upd_vec_i(eff_vec),
    .act_o(act_flags), .acc_o(acc_flags), .rdata_o(exc_rdata)
  );

  assign unused_flags = ^{act_flags, acc_flags};

  fp_trap_gen #(
    .EXC_W(EXC_W)
  ) u_trap (
    .clk(clk), .rst(rst), .upd_i(op_done), .is_cmp_i(op_cmp),
    .vec_i(eff_vec), .te_i(trap_en),
    .trap_o(trap_req), .flag_we_o(flag_we)
  );

endmodule

// File: rtl/fp_exc_ctrl_chk.sv
module fp_exc_ctrl_chk #(
  parameter int WORD_W  = 32,
  parameter int EXC_W   = 5,
  parameter int RM_W    = 2,
  parameter int TE_LSB  = 8,
  parameter int ACT_LSB = 8,
  parameter int ACC_LSB = 0,
  parameter int NAN_LO  = 19,
  parameter int NAN_HI  = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [WORD_W-1:0] ctl_rdata,
  input logic [RM_W-1:0]   rnd_mode,
  input logic              exc_we,
  input logic [WORD_W-1:0] exc_rdata,
  input logic              op_done,
  input logic [EXC_W-1:0]  op_exc,
  input logic [WORD_W-1:0] op_a_hi,
  input logic              op_cmp,
  input logic [1:0]        a_class,
  input logic [1:0]        b_class,
  input logic              trap_req,
  input logic              flag_we
);

  localparam int INV = EXC_W - 1;

  p_accrued_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !exc_we |=> ((exc_rdata[ACC_LSB +: EXC_W] & $past(exc_rdata[ACC_LSB +: EXC_W]))
                 == $past(exc_rdata[ACC_LSB +: EXC_W])));

  p_actual_load_r4: assert property (@(posedge clk) disable iff (rst)
    op_done |=> (exc_rdata[ACT_LSB +: INV] == $past(op_exc[INV-1:0])));

  p_snan_invalid_r8: assert property (@(posedge clk) disable iff (rst)
    op_done |=> (!(a_class == 2'b10 || b_class == 2'b10) || exc_rdata[ACT_LSB + INV]));

  p_nan_detect_r6: assert property (@(posedge clk) disable iff (rst)
    op_done |=> ((a_class != 2'b00) == (&$past(op_a_hi[NAN_HI:NAN_LO]))));

  p_trap_match_r9: assert property (@(posedge clk) disable iff (rst)
    (op_done && !ctl_we) |=>
      (trap_req == (|(exc_rdata[ACT_LSB +: EXC_W] & ctl_rdata[TE_LSB +: EXC_W]))));

  p_trap_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !op_done |=> !trap_req);

  p_flag_we_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_we == $past(op_done && op_cmp)));

  p_rm_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(rnd_mode));

endmodule

bind fp_exc_ctrl fp_exc_ctrl_chk #(
  .WORD_W(WORD_W), .EXC_W(EXC_W), .RM_W(RM_W), .TE_LSB(TE_LSB),
  .ACT_LSB(ACT_LSB), .ACC_LSB(ACC_LSB), .NAN_LO(NAN_LO), .NAN_HI(NAN_HI)
) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
  .rnd_mode(rnd_mode), .exc_we(exc_we), .exc_rdata(exc_rdata),
  .op_done(op_done), .op_exc(op_exc), .op_a_hi(op_a_hi), .op_cmp(op_cmp),
  .a_class(a_class), .b_class(b_class), .trap_req(trap_req), .flag_we(flag_we)
);

// File: tb/tb_fp_exc_ctrl.sv
`timescale 1ns/1ps
module tb_fp_exc_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_we, exc_we, op_done, op_cmp;
  logic [31:0] ctl_wdata, exc_wdata, op_a_hi, op_b_hi;
  logic [4:0]  op_exc;
  logic [31:0] ctl_rdata, exc_rdata;
  logic [1:0]  rnd_mode, a_class, b_class;
  logic        trap_req, flag_we;

  always #4 clk = ~clk;

  fp_exc_ctrl dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rnd_mode(rnd_mode), .exc_we(exc_we),
    .exc_wdata(exc_wdata), .exc_rdata(exc_rdata), .op_done(op_done),
    .op_exc(op_exc), .op_a_hi(op_a_hi), .op_b_hi(op_b_hi), .op_cmp(op_cmp),
    .a_class(a_class), .b_class(b_class), .trap_req(trap_req), .flag_we(flag_we)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit live = 0;

  logic [1:0] m_rm, m_ca, m_cb;
  logic [4:0] m_te, m_act, m_acc, vec;
  logic       m_trap, m_flag;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] cls(logic [31:0] w);
    if (w[30:19] != 12'hFFF) return 2'b00;
    return w[0] ? 2'b10 : 2'b01;
  endfunction

  // Behavioural reference, updated on every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_rm = 0; m_te = 0; m_act = 0; m_acc = 0;
      m_trap = 0; m_flag = 0; m_ca = 0; m_cb = 0;
      live = 1;
    end else begin
      m_trap = 0; m_flag = 0;
      if (op_done) begin
        vec = op_exc;
        if (cls(op_a_hi) == 2'b10 || cls(op_b_hi) == 2'b10) vec[4] = 1'b1;
        m_trap = (vec & m_te) != 0;
        m_flag = op_cmp;
        m_act  = vec;
        m_acc  = m_acc | vec;
        m_ca   = cls(op_a_hi);
        m_cb   = cls(op_b_hi);
      end else if (exc_we) begin
        m_act = exc_wdata[12:8];
        m_acc = exc_wdata[4:0];
      end
      if (ctl_we) begin
        m_rm = ctl_wdata[14:13];
        m_te = ctl_wdata[12:8];
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R1 rnd_mode", {30'd0, rnd_mode}, {30'd0, m_rm});
      chk("R2 ctl_rdata", ctl_rdata, {17'd0, m_rm, m_te, 8'd0});
      chk("R3 exc_rdata", exc_rdata, {19'd0, m_act, 3'd0, m_acc});
      chk("R6 a_class", {30'd0, a_class}, {30'd0, m_ca});
      chk("R7 b_class", {30'd0, b_class}, {30'd0, m_cb});
      chk("R9 trap_req", {31'd0, trap_req}, {31'd0, m_trap});
      chk("R10 flag_we", {31'd0, flag_we}, {31'd0, m_flag});
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_op(logic [31:0] a, logic [31:0] b, logic [4:0] e, logic c);
    op_done = 1; op_a_hi = a; op_b_hi = b; op_exc = e; op_cmp = c;
    tick();
    op_done = 0; op_cmp = 0;
  endtask

  task automatic do_ctl(logic [31:0] w);
    ctl_we = 1; ctl_wdata = w;
    tick();
    ctl_we = 0;
  endtask

  task automatic do_excw(logic [31:0] w);
    exc_we = 1; exc_wdata = w;
    tick();
    exc_we = 0;
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 3)
      0: return r;
      1: return r | 32'h7FF8_0000;
      default: return (r | 32'h7FF0_0000) & ~32'h0008_0000;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; ctl_we = 0; exc_we = 0; op_done = 0; op_cmp = 0;
    ctl_wdata = 0; exc_wdata = 0; op_exc = 0; op_a_hi = 0; op_b_hi = 0;
    repeat (3) tick();
    rst = 0;
    // R12: reset state
    chk("R12 exc_rdata after reset", exc_rdata, 32'h0);
    chk("R12 ctl_rdata after reset", ctl_rdata, 32'h0);
    chk("R12 trap_req after reset", {31'd0, trap_req}, 32'h0);

    // R1/R2: rm=10, te=10000 (invalid only), reserved control bits dropped
    do_ctl(32'hFFFF_D0FF);
    chk("R1 rnd_mode toward minus inf", {30'd0, rnd_mode}, 32'h2);
    chk("R2 ctl_rdata", ctl_rdata, 32'h0000_5000);

    // R6/R4: quiet NaN A, plain B, inexact only
    do_op(32'h7FF8_0000, 32'h3F80_0000, 5'b00001, 0);
    chk("R6 quiet NaN class", {30'd0, a_class}, 32'h1);
    chk("R4 exc word after inexact", exc_rdata, 32'h0000_0101);
    chk("R9 masked inexact no trap", {31'd0, trap_req}, 32'h0);

    // R8/R9: signaling NaN A, payload-heavy quiet NaN B
    do_op(32'h7FF8_0001, 32'hFFFF_FFFE, 5'b00000, 0);
    chk("R8 signaling class", {30'd0, a_class}, 32'h2);
    chk("R7 payload quiet class", {30'd0, b_class}, 32'h1);
    chk("R8 invalid forced", exc_rdata, 32'h0000_1011);
    chk("R9 trap raised", {31'd0, trap_req}, 32'h1);

    // R7: near-miss words, bit 19 clear
    do_op(32'h7FF7_FFFF, 32'h0007_FFFF, 5'b00100, 0);
    chk("R7 near miss A", {30'd0, a_class}, 32'h0);
    chk("R4 accrued sticky", exc_rdata, 32'h0000_0415);
    chk("R9 trap one cycle", {31'd0, trap_req}, 32'h0);

    // R5/R11: software writes
    do_excw(32'hFFFF_FFFF);
    chk("R5 reserved bits zero", exc_rdata, 32'h0000_1F1F);
    do_excw(32'h0);
    chk("R11 software clear", exc_rdata, 32'h0);

    // R11: collision, strobe wins
    exc_we = 1; exc_wdata = 32'h0000_1F1F;
    do_op(32'h0, 32'h0, 5'b00010, 0);
    exc_we = 0;
    chk("R11 strobe beats write", exc_rdata, 32'h0000_0202);

    // R10: compare completion
    do_op(32'h0, 32'h0, 5'b00000, 1);
    chk("R10 flag_we on compare", {31'd0, flag_we}, 32'h1);
    do_op(32'h0, 32'h0, 5'b00000, 0);
    chk("R10 flag_we off otherwise", {31'd0, flag_we}, 32'h0);

    // Random traffic checked against the reference every clock
    repeat (600) begin
      op_done   = ($urandom % 2) == 0;
      op_cmp    = ($urandom % 3) == 0;
      op_exc    = 5'($urandom);
      op_a_hi   = rand_word();
      op_b_hi   = rand_word();
      ctl_we    = ($urandom % 8) == 0;
      ctl_wdata = $urandom;
      exc_we    = ($urandom % 6) == 0;
      exc_wdata = $urandom;
      tick();
    end
    op_done = 0; ctl_we = 0; exc_we = 0; op_cmp = 0;
    repeat (3) tick();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule